// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received Ethernet frame as a byte stream and stores it in memory. The memory is a ring of fixed-size data buffers, and each buffer is described by a two-word descriptor in memory. Before the block fills a buffer, it reads the descriptor's address word to see whether software still owns the buffer. It then writes the frame bytes into the buffer one byte lane at a time. When the buffer is full or the frame ends, it closes the buffer with two writes. The first write stores a status word holding start, end, broadcast and length information. The second rewrites the address word with its ownership flag set.

A frame longer than one buffer continues into the following descriptor. The walk through the ring restarts at the ring base after a descriptor whose address word carries the wrap flag. If the engine finds a descriptor still marked as used when it needs a buffer, it signals that no buffer is available and discards the remainder of the frame. The next frame then tries the same descriptor again. Software hands buffers back by clearing the used flag.

Top module: `rx_ring_writer`

## Requirements
- R1: Byte n of a buffer (n counted from 0) is written to buffer address + n. Each accepted byte causes one memory write whose byte enable has exactly one bit set, lane n mod 4, little-endian within the 32-bit word. The byte value appears in that lane of the write data.
- R2: Before filling each buffer, the engine reads the address word at ring_base + 8 × (descriptor index). While that read is outstanding, rx_ready is low. No byte is written to a buffer whose address word has bit 0 set.
- R3: The buffer address is the address word with bits 1:0 forced to zero.
- R4: A buffer is closed after BUF_BYTES (128) bytes or after the byte marked end-of-frame, whichever comes first. The rest of the frame continues in the next descriptor's buffer. A frame of exactly 128 bytes uses one descriptor.
- R5: The status word is written at descriptor + 4. Bit 14 is set only for the frame's first buffer. Bit 15 is set only for its last buffer. Bits 11:0 hold the total frame length in the last buffer's status and zero in the others. Bit 31 copies rx_bcast as sampled with the frame's first byte. All other bits are zero.
- R6: The status word is written first. In the next cycle the address word is rewritten with bit 0 set and all other bits unchanged.
- R7: The next descriptor is at the current one + 8. If the current address word has bit 1 set, the next descriptor is ring_base instead.
- R8: When the fetched address word has bit 0 set, buf_unavail is high for exactly one cycle. The remaining bytes of the frame, through the end-of-frame byte, are accepted and discarded. The descriptor pointer does not move, so the next frame tries the same descriptor again.
- R9: While idle, bytes presented without the start-of-frame marker are accepted and discarded, with no memory access.
- R10: After reset the memory port is inactive, buf_unavail is low, and the first frame uses the descriptor at ring_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| rx_valid | input | 1 | A byte is offered on rx_data |
| rx_ready | output | 1 | The offered byte is taken at this clock edge |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_bcast | input | 1 | Frame has a broadcast destination (sampled with the first byte) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte enables of a write |
| mem_addr | output | ADDR_W | Byte address of the accessed word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| buf_unavail | output | 1 | One-cycle pulse: the needed descriptor was still marked used |

## Verification
The bench targets frames sized around the buffer boundary. A 128-byte frame catches a design that opens an empty extra buffer or leaves the end flag off. A 129-byte frame catches one that loses the single spilled byte or reports a per-buffer length instead of the frame total. A 1514-byte frame runs through the descriptor carrying the wrap flag and finishes at the ring base. A design that ignores the wrap flag would write past the ring. A design that fails to mask the flag out of the buffer address would shift that buffer's bytes. A descriptor that software still holds is placed in the middle of a frame and again at the start of the next frame. This exposes designs that overwrite it, stall on the leftover bytes, or skip past it instead of retrying it.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_FILL,
      ST_CLOSE_ST,
      ST_CLOSE_AD,
      ST_DROP
   } rxr_state_t;

   localparam int OWN_BIT    = 0;
   localparam int WRAP_BIT   = 1;
   localparam int SOF_BIT    = 14;
   localparam int EOF_BIT    = 15;
   localparam int BCAST_BIT  = 31;
   localparam int DESC_BYTES = 8;
   localparam int STAT_OFS   = 4;
endpackage

// File: rtl/rxr_desc_ptr.sv
`timescale 1ns/1ps
module rxr_desc_ptr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              step,
   input  logic              wrap,
   output logic [ADDR_W-1:0] desc_addr
);
   import rxr_pkg::*;

   logic [ADDR_W-1:0] ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ofs_q <= '0;
      else if (step)
         ofs_q <= wrap ? '0 : ofs_q + ADDR_W'(DESC_BYTES);
   end

   assign desc_addr = ring_base + ofs_q;
endmodule

// File: rtl/rxr_frame_track.sv
`timescale 1ns/1ps
module rxr_frame_track #(
   parameter int BUF_BYTES = 128,
   parameter int LEN_W     = 12,
   localparam int OFS_W    = $clog2(BUF_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic             take_eof,
   input  logic             take_bcast,
   input  logic             buf_done,
   output logic [OFS_W-1:0] buf_ofs,
   output logic [LEN_W-1:0] frame_len,
   output logic             last_byte,
   output logic             first_buf,
   output logic             eof_seen,
   output logic             bcast_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_ofs   <= '0;
         frame_len <= '0;
         first_buf <= 1'b0;
         eof_seen  <= 1'b0;
         bcast_q   <= 1'b0;
      end else if (start) begin
         buf_ofs   <= '0;
         frame_len <= '0;
         first_buf <= 1'b1;
         eof_seen  <= 1'b0;
         bcast_q   <= 1'b0;
      end else begin
         if (take) begin
            buf_ofs   <= buf_ofs + OFS_W'(1);
            frame_len <= frame_len + LEN_W'(1);
            if (take_eof)
               eof_seen <= 1'b1;
            if (frame_len == '0)
               bcast_q <= take_bcast;
         end
         if (buf_done)
            first_buf <= 1'b0;
      end
   end

   assign last_byte = (buf_ofs == OFS_W'(BUF_BYTES - 1));
endmodule

// File: rtl/rxr_lane.sv
`timescale 1ns/1ps
module rxr_lane #(
   parameter int LANES = 4,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [7:0]         data,
   output logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] wdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be[g]          = (sel == SEL_W'(g));
      assign wdata[8*g +: 8] = data;
   end
endmodule

// File: rtl/rxr_fsm.sv
`timescale 1ns/1ps
module rxr_fsm (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_valid,
   input  logic                rx_sof,
   input  logic                rx_eof,
   input  logic                used_flag,
   input  logic                last_byte,
   input  logic                eof_seen,
   output rxr_pkg::rxr_state_t state,
   output logic                rx_ready,
   output logic                frame_start,
   output logic                take,
   output logic                latch_desc,
   output logic                step,
   output logic                bna
);
   import rxr_pkg::*;

   rxr_state_t nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

   always_comb begin
      nxt         = state;
      rx_ready    = 1'b0;
      frame_start = 1'b0;
      latch_desc  = 1'b0;
      step        = 1'b0;
      bna         = 1'b0;
      unique case (state)
         ST_IDLE: begin
            rx_ready = !rx_sof;
            if (rx_valid && rx_sof) begin
               frame_start = 1'b1;
               nxt         = ST_FETCH;
            end
         end
         ST_FETCH: nxt = ST_WAIT;
         ST_WAIT: begin
            if (used_flag) begin
               bna = 1'b1;
               nxt = ST_DROP;
            end else begin
               latch_desc = 1'b1;
               nxt        = ST_FILL;
            end
         end
         ST_FILL: begin
            rx_ready = 1'b1;
            if (rx_valid && (rx_eof || last_byte))
               nxt = ST_CLOSE_ST;
         end
         ST_CLOSE_ST: nxt = ST_CLOSE_AD;
         ST_CLOSE_AD: begin
            step = 1'b1;
            nxt  = eof_seen ? ST_IDLE : ST_FETCH;
         end
         ST_DROP: begin
            rx_ready = 1'b1;
            if (rx_valid && rx_eof)
               nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign take = (state == ST_FILL) && rx_valid;
endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer #(
   parameter int ADDR_W    = 32,
   parameter int BUF_BYTES = 128,
   parameter int LEN_W     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_bcast,
   output logic              mem_en,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              buf_unavail
);
   import rxr_pkg::*;

   localparam int OFS_W = $clog2(BUF_BYTES);

   if (BUF_BYTES < 4 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 4");
   end
   if (LEN_W > SOF_BIT || (1 << LEN_W) <= BUF_BYTES) begin : g_bad_len
      $error("LEN_W must fit below the start flag and exceed one buffer");
   end
   if (ADDR_W > 32 || ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must lie between the buffer offset width and 32");
   end

   rxr_state_t        state;
   logic              frame_start, take, latch_desc, step;
   logic [ADDR_W-1:0] desc_addr;
   logic [31:0]       addr_word_q;
   logic [OFS_W-1:0]  buf_ofs;
   logic [LEN_W-1:0]  frame_len;
   logic              last_byte, first_buf, eof_seen, bcast_q;
   logic [3:0]        lane_be;
   logic [31:0]       lane_wdata;
   logic [31:0]       aligned_word;
   logic [ADDR_W-1:0] buf_base;
   logic [OFS_W-1:0]  word_ofs;
   logic [31:0]       status_w;

   rxr_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_valid    (rx_valid),
      .rx_sof      (rx_sof),
      .rx_eof      (rx_eof),
      .used_flag   (mem_rdata[OWN_BIT]),
      .last_byte   (last_byte),
      .eof_seen    (eof_seen),
      .state       (state),
      .rx_ready    (rx_ready),
      .frame_start (frame_start),
      .take        (take),
      .latch_desc  (latch_desc),
      .step        (step),
      .bna         (buf_unavail)
   );

   rxr_desc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_base (ring_base),
      .step      (step),
      .wrap      (addr_word_q[WRAP_BIT]),
      .desc_addr (desc_addr)
   );

   rxr_frame_track #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (frame_start),
      .take       (take),
      .take_eof   (rx_eof),
      .take_bcast (rx_bcast),
      .buf_done   (step),
      .buf_ofs    (buf_ofs),
      .frame_len  (frame_len),
      .last_byte  (last_byte),
      .first_buf  (first_buf),
      .eof_seen   (eof_seen),
      .bcast_q    (bcast_q)
   );

   rxr_lane #(.LANES(4)) u_lane (
      .sel   (buf_ofs[1:0]),
      .data  (rx_data),
      .be    (lane_be),
      .wdata (lane_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_word_q <= '0;
      else if (latch_desc)
         addr_word_q <= mem_rdata;
   end

   assign aligned_word = {addr_word_q[31:2], 2'b00};
   assign buf_base     = aligned_word[ADDR_W-1:0];
   assign word_ofs     = {buf_ofs[OFS_W-1:2], 2'b00};

   always_comb begin
      status_w            = '0;
      status_w[LEN_W-1:0] = eof_seen ? frame_len : '0;
      status_w[SOF_BIT]   = first_buf;
      status_w[EOF_BIT]   = eof_seen;
      status_w[BCAST_BIT] = bcast_q;
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_be    = '0;
      mem_addr  = desc_addr;
      mem_wdata = '0;
      unique case (state)
         ST_FETCH: mem_en = 1'b1;
         ST_FILL: begin
            mem_en    = rx_valid;
            mem_we    = 1'b1;
            mem_be    = lane_be;
            mem_addr  = buf_base + ADDR_W'(word_ofs);
            mem_wdata = lane_wdata;
         end
         ST_CLOSE_ST: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_addr  = desc_addr + ADDR_W'(STAT_OFS);
            mem_wdata = status_w;
         end
         ST_CLOSE_AD: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_wdata = addr_word_q | 32'h1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rxr_checker.sv
`timescale 1ns/1ps
module rxr_checker #(
   parameter int ADDR_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rx_ready,
   input logic                mem_en,
   input logic                mem_we,
   input logic [3:0]          mem_be,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic                own_bit,
   input logic                buf_unavail,
   input rxr_pkg::rxr_state_t st
);
   import rxr_pkg::*;

   // R2: descriptor read issued, no byte taken meanwhile
   p_desc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |-> (mem_en && !mem_we && !rx_ready));

   // R1: each buffer write touches a single byte lane
   p_one_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && mem_en) |-> (mem_we && $countones(mem_be) == 1));

   // R6: status write is followed by the ownership write 4 bytes lower
   p_status_then_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CLOSE_ST) |=> (mem_en && mem_we && own_bit &&
                               mem_addr == $past(mem_addr) - ADDR_W'(4)));

   // R4: no byte is taken while a buffer is being closed
   p_closing_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CLOSE_ST || st == ST_CLOSE_AD) |-> !rx_ready);

   // R8: single-cycle busy pulse, then the frame remainder is discarded
   p_bna_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_unavail |=> (!buf_unavail && st == ST_DROP));
endmodule

bind rx_ring_writer rxr_checker #(.ADDR_W(ADDR_W)) u_rxr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_ready    (rx_ready),
   .mem_en      (mem_en),
   .mem_we      (mem_we),
   .mem_be      (mem_be),
   .mem_addr    (mem_addr),
   .own_bit     (mem_wdata[0]),
   .buf_unavail (buf_unavail),
   .st          (state)
);

// File: tb/rx_ring_writer_bench.sv
`timescale 1ns/1ps
module rx_ring_writer_bench;
   localparam int AW       = 32;
   localparam int RING_W   = 64;      // word index of ring base 0x100
   localparam int NDESC    = 16;
   localparam int NVEC     = 4;
   localparam int VEC_LEN   [NVEC] = '{60, 128, 129, 60};
   localparam int VEC_BC    [NVEC] = '{0, 1, 0, 0};
   localparam int VEC_FIRST [NVEC] = '{0, 1, 2, 4};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_bcast = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          rx_ready, mem_en, mem_we, buf_unavail;
   logic [3:0]    mem_be;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   rdata_q = '0;
   logic [31:0]   mem [0:4095];

   int checks = 0, errors = 0, bna_cnt = 0, wr_cnt = 0;

   always #10 clk = ~clk;

   rx_ring_writer u_rx_ring_writer (
      .clk(clk), .rst_n(rst_n), .ring_base(32'h100),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_bcast(rx_bcast),
      .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .buf_unavail(buf_unavail)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            rdata_q <= mem[mem_addr[13:2]];
         end
      end
   end

   always @(negedge clk) begin
      if (buf_unavail) bna_cnt++;
      if (mem_en && mem_we) wr_cnt++;
   end

   function automatic logic [31:0] desc_init(int d);
      return (32'h1000 + 32'(128 * d)) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
   endfunction

   function automatic logic [7:0] pat(int fid, int i);
      return 8'((fid * 41 + i * 7 + (i >> 8)) & 255);
   endfunction

   function automatic logic [7:0] rd_byte(logic [31:0] a);
      logic [31:0] w;
      w = mem[a[13:2]];
      return w[8*a[1:0] +: 8];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input int fid, input int len, input bit bc);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = pat(fid, i);
         rx_sof = (i == 0); rx_eof = (i == len - 1); rx_bcast = bc;
         #1;
         while (!rx_ready) begin @(negedge clk); #1; end
         @(posedge clk);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_bcast = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_stray(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = 8'hA5; rx_sof = 1'b0; rx_eof = 1'b0;
         #1;
         while (!rx_ready) begin @(negedge clk); #1; end
         @(posedge clk);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // R1 R3 R4 R5 R6 R7: every descriptor of a frame and its buffer bytes
   task automatic check_frame(input int fid, input int len, input bit bc, input int first);
      int nd;
      nd = (len + 127) / 128;
      for (int k = 0; k < nd; k++) begin
         int d, nb, bad;
         bit last;
         logic [31:0] exp_cw, base;
         d = (first + k) % NDESC;
         last = (k == nd - 1);
         nb = last ? len - 128 * k : 128;
         base = 32'h1000 + 32'(128 * d);
         exp_cw = (32'(k == 0) << 14) | (32'(last) << 15) |
                  (last ? 32'(len) : 32'h0) | (32'(bc) << 31);
         chk(mem[RING_W + 2*d] == (desc_init(d) | 32'h1), "R6/R7", "address word",
             mem[RING_W + 2*d], desc_init(d) | 32'h1);
         chk(mem[RING_W + 2*d + 1] == exp_cw, "R4/R5", "status word",
             mem[RING_W + 2*d + 1], exp_cw);
         bad = 0;
         for (int j = 0; j < nb; j++)
            if (rd_byte(base + 32'(j)) != pat(fid, 128 * k + j)) bad++;
         chk(bad == 0, "R1/R3", "buffer data mismatches", 32'(bad), 32'h0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] saved;
      int b0, w0;
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      @(negedge clk);
      for (int d = 0; d < NDESC; d++) mem[RING_W + 2*d] <= desc_init(d);
      repeat (3) @(negedge clk);
      // R10: reset holds the memory port quiet
      chk(mem_en == 1'b0 && buf_unavail == 1'b0, "R10", "port idle in reset",
          {30'h0, mem_en, buf_unavail}, 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mem_en == 1'b0, "R10", "port idle after reset", {31'h0, mem_en}, 32'h0);

      // R9: stray bytes in idle are swallowed without memory traffic
      w0 = wr_cnt;
      send_stray(3);
      chk(wr_cnt == w0 && mem_en == 1'b0, "R9", "writes after stray bytes",
          32'(wr_cnt - w0), 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         send_frame(v + 1, VEC_LEN[v], VEC_BC[v] != 0);
         check_frame(v + 1, VEC_LEN[v], VEC_BC[v] != 0, VEC_FIRST[v]);
      end

      // R7: long frame running through the wrap descriptor back to the base
      for (int d = 0; d < 5; d++) begin
         mem[RING_W + 2*d]     <= desc_init(d);
         mem[RING_W + 2*d + 1] <= '0;
      end
      @(negedge clk);
      send_frame(5, 1514, 1'b0);
      check_frame(5, 1514, 1'b0, 5);

      // R8/R2: busy descriptor in the middle of a frame
      mem[RING_W + 4] <= desc_init(2) | 32'h1;
      mem[RING_W + 5] <= 32'h0000_0ABC;
      @(negedge clk);
      saved = mem[(32'h1000 + 256) >> 2];
      b0 = bna_cnt;
      send_frame(6, 200, 1'b0);
      chk(bna_cnt - b0 == 1, "R8", "busy pulses mid frame", 32'(bna_cnt - b0), 32'h1);
      chk(mem[RING_W + 3] == 32'h4000, "R8", "partial frame status",
          mem[RING_W + 3], 32'h4000);
      chk(mem[RING_W + 5] == 32'h0000_0ABC, "R2", "busy descriptor status kept",
          mem[RING_W + 5], 32'h0000_0ABC);
      chk(mem[(32'h1000 + 256) >> 2] == saved, "R2", "busy buffer untouched",
          mem[(32'h1000 + 256) >> 2], saved);

      // R8: next frame retries the same descriptor
      b0 = bna_cnt;
      send_frame(7, 20, 1'b0);
      chk(bna_cnt - b0 == 1, "R8", "busy pulses on retry", 32'(bna_cnt - b0), 32'h1);
      chk(mem[RING_W + 4] == (desc_init(2) | 32'h1), "R8", "busy address word kept",
          mem[RING_W + 4], desc_init(2) | 32'h1);

      // R8: once released, that descriptor takes the following frame
      mem[RING_W + 4] <= desc_init(2);
      @(negedge clk);
      send_frame(8, 20, 1'b1);
      check_frame(8, 20, 1'b1, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule